// File: doc/BRIEF.md
# Qualified Sync Burst Generator

This block sits on the transmit side of a serial link, just ahead of the serializer. It normally forwards an 18-bit user word on every word clock. When a sync request has been held high long enough to count as deliberate, it puts a fixed training word on the payload in place of user data for a fixed number of word clocks. It then hands the payload back to the user. The training word is a block of nine ones next to a block of nine zeros, so the serial line carries a square wave at the word rate that a far-end clock recovery circuit can lock to.

The request input may be tied straight to the far end's active-low lock indication. That input then stays high for as long as the link is down, and the block keeps sending bursts with no gaps until the far end reports lock. User words that arrive during a burst are dropped, not stored. The busy output marks every cycle that carries a training word.

Top module: `sync_burst_gen`

## Requirements
- R1: While busy_o is high, payload_o equals 18'h001FF: bits 0 to 8 are one and bits 9 to 17 are zero, with bit 0 sent first on the line.
- R2: While busy_o is low, payload_o equals data_i in the same cycle.
- R3: A request sampled high on six or fewer consecutive rising edges and then sampled low starts no burst, and busy_o stays low.
- R4: When sync_i is sampled high on a seventh consecutive rising edge while idle, busy_o is high from the next cycle.
- R5: Once started, a burst keeps busy_o high for exactly 1026 consecutive cycles.
- R6: If sync_i is sampled high in the last burst cycle and has been high on at least seven consecutive edges including that one, a new 1026-cycle burst follows with no idle cycle in between.
- R7: A single low sample clears the qualification count, so six highs, one low, then six highs start no burst.
- R8: busy_o is high in exactly those cycles in which payload_o carries the training word in place of user data.
- R9: Asserting rst_ni low ends any burst at once and forces busy_o low with payload_o following data_i. The qualification count restarts from zero.
- R10: Short request pulses during a burst do not lengthen it. The burst ends after 1026 cycles unless the R6 condition holds in its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Sync request, level sensitive |
| data_i | input | 18 | User payload word |
| payload_o | output | 18 | Word passed on to the serializer |
| busy_o | output | 1 | High while a training word is being sent |

## Verification
The bench probes the width threshold at both sides. A six-cycle pulse must be ignored and a seven-cycle pulse must fire, so an off-by-one in the qualifier shows up as a missing or spurious burst. It counts every burst cycle against 1026, which catches a length counter that ends one word early or late. It holds the request high across burst boundaries to expose a gap cycle or a missed restart. It splits a request with a single low sample to catch a counter that does not clear. It asserts reset in the middle of a burst to catch training words that leak out after reset.

// File: rtl/sync_burst_pkg.sv
`timescale 1ns/1ps
package sync_burst_pkg;
  localparam int unsigned WORD_W_DEF    = 18;
  localparam int unsigned MIN_HIGH_DEF  = 6;
  localparam int unsigned BURST_LEN_DEF = 1026;

  // lower half ones, upper half zeros (bit 0 leaves first)
  function automatic logic train_bit(input int unsigned idx, input int unsigned width);
    return (idx < width / 2);
  endfunction
endpackage

// File: rtl/sync_qualifier.sv
`timescale 1ns/1ps
module sync_qualifier #(
  parameter int unsigned MIN_HIGH = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic qual_o
);
  localparam int unsigned CNT_W = $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_HIGH);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!sync_i) begin
      run_q <= '0;
    end else if (run_q != CNT_SAT) begin
      run_q <= run_q + 1'b1;
    end
  end

  // current sample is the (MIN_HIGH+1)th consecutive high
  assign qual_o = sync_i && (run_q == CNT_SAT);

  p_qual_needs_prev_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> $past(sync_i));

  p_low_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> !qual_o);
endmodule

// File: rtl/burst_timer.sv
`timescale 1ns/1ps
module burst_timer #(
  parameter int unsigned BURST_LEN = 1026
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  output logic busy_o
);
  localparam int unsigned REM_W = $clog2(BURST_LEN);
  localparam logic [REM_W-1:0] REM_INIT = REM_W'(BURST_LEN - 1);

  logic             busy_q;
  logic [REM_W-1:0] rem_q;
  logic             last_w;
  logic             start_w;

  assign last_w  = busy_q && (rem_q == '0);
  assign start_w = qual_i && (!busy_q || last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (start_w) begin
      busy_q <= 1'b1;
      rem_q  <= REM_INIT;
    end else if (busy_q) begin
      if (rem_q == '0) busy_q <= 1'b0;
      else             rem_q  <= rem_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  p_start_after_qual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(qual_i));

  p_no_early_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rem_q != '0) |=> busy_q);

  p_back_to_back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_w && qual_i) |=> (busy_q && rem_q == REM_INIT));

  p_idle_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !qual_i) |=> !busy_q);
endmodule

// File: rtl/payload_mux.sv
`timescale 1ns/1ps
module payload_mux #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              sel_train_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] payload_o
);
  import sync_burst_pkg::*;

  logic [WORD_W-1:0] train_w;

  for (genvar b = 0; b < WORD_W; b++) begin : g_train
    assign train_w[b] = train_bit(b, WORD_W);
  end

  assign payload_o = sel_train_i ? train_w : data_i;

  always_comb begin
    a_half_ones_r1: assert ($countones(train_w) == WORD_W / 2);
  end
endmodule

// File: rtl/sync_burst_gen.sv
`timescale 1ns/1ps
module sync_burst_gen #(
  parameter int unsigned WORD_W    = sync_burst_pkg::WORD_W_DEF,
  parameter int unsigned MIN_HIGH  = sync_burst_pkg::MIN_HIGH_DEF,
  parameter int unsigned BURST_LEN = sync_burst_pkg::BURST_LEN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] payload_o,
  output logic              busy_o
);
  logic qual_w;
  logic busy_w;

  sync_qualifier #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .qual_o (qual_w)
  );

  burst_timer #(.BURST_LEN(BURST_LEN)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qual_i (qual_w),
    .busy_o (busy_w)
  );

  payload_mux #(.WORD_W(WORD_W)) u_mux (
    .sel_train_i (busy_w),
    .data_i      (data_i),
    .payload_o   (payload_o)
  );

  assign busy_o = busy_w;

  p_busy_needs_request_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_w) |-> $past(sync_i));
endmodule

// File: tb/sync_burst_gen_tb_top.sv
`timescale 1ns/1ps
module sync_burst_gen_tb_top;
  localparam int W = 18;
  localparam int NEED = 7;
  localparam int BLEN = 1026;
  localparam logic [W-1:0] PAT = 18'h001FF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_r = 1'b0;
  logic [W-1:0] data_r = '0;
  logic [W-1:0] payload;
  logic         busy;

  int vectors = 0;
  int misses = 0;
  int run_len = 0;
  int left = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_burst_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_r),
    .data_i(data_r), .payload_o(payload), .busy_o(busy)
  );

  function automatic logic [W-1:0] exp_payload(input bit b, input logic [W-1:0] d);
    return b ? PAT : d;
  endfunction

  task automatic compare(input string tag);
    bit eb;
    eb = (left > 0);
    vectors++;
    if (busy !== eb || payload !== exp_payload(eb, data_r)) begin
      misses++;
      $display("FAIL %s: busy=%0b payload=%05h expected busy=%0b payload=%05h",
               tag, busy, payload, eb, exp_payload(eb, data_r));
    end
  endtask

  // called at negedge: drive, check, advance model to next edge
  task automatic step(input bit s, input string tag);
    int nrun;
    sync_r = s;
    data_r = W'($urandom);
    #1;
    compare(tag);
    nrun = s ? run_len + 1 : 0;
    if (left <= 1 && s && nrun >= NEED) left = BLEN;
    else if (left > 0) left--;
    run_len = nrun;
    @(negedge clk);
  endtask

  task automatic steps(input bit s, input int n, input string tag);
    for (int i = 0; i < n; i++) step(s, tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    sync_r = 1'b0;
    data_r = W'($urandom);
    #1;
    left = 0;
    run_len = 0;
    compare(tag);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_burst(input string tag);
    int n = 0;
    for (int i = 0; i < BLEN + 20; i++) begin
      if (busy === 1'b1) n++;
      step(1'b0, tag);
    end
    vectors++;
    if (n != BLEN) begin
      misses++;
      $display("FAIL %s: burst length actual=%0d expected=%0d", tag, n, BLEN);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    do_reset("R9");
    steps(1'b0, 4, "R2 R9");

    steps(1'b1, 6, "R3"); steps(1'b0, 8, "R3");
    steps(1'b1, 6, "R7"); steps(1'b0, 1, "R7"); steps(1'b1, 6, "R7"); steps(1'b0, 8, "R7");

    steps(1'b1, NEED, "R4");
    count_burst("R1 R5 R8");

    steps(1'b1, NEED + 2 * BLEN + 30, "R6");
    steps(1'b0, BLEN + 10, "R6");

    steps(1'b1, NEED, "R4");
    for (int k = 0; k < 200; k++) begin
      steps(1'b1, 3, "R10"); steps(1'b0, 2, "R10");
    end
    steps(1'b0, 100, "R10");

    steps(1'b1, NEED, "R4");
    steps(1'b0, 100, "R1 R8");
    do_reset("R9");
    steps(1'b0, 5, "R9");
    steps(1'b1, 6, "R9"); steps(1'b0, 5, "R9");

    for (int seg = 0; seg < 60; seg++) begin
      int hi = 1 + int'($urandom_range(11));
      int lo = 1 + int'($urandom_range(1200));
      steps(1'b1, hi, "R3 R4 R6");
      steps(1'b0, lo, "R5 R10");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule